// File: doc/BRIEF.md
# Burst-Mode Oscillator Calibration Sequencer

This block calibrates a frequency-locked oscillator in short bursts instead of leaving the lock loop running all the time. When the period tick `start` arrives while the block is idle, it first switches off the enable for every consumer clocked from the oscillator, such as the serial port and the timers. It then turns the lock loop on for a fixed number of reference periods so the loop can settle, and turns it off again. With the loop off, it counts oscillator cycles over a set number of reference periods and compares that count with an upper bound `cnt_hi`.

A count above the bound means the oscillator is still running fast, so the sequencer runs the loop again and measures again. A count within the bound ends the sequence. The consumers are enabled again and `done` pulses. If too many bursts in a row measure high, the sequence still ends with the consumers enabled, and an error flag is set. The reference clock is asynchronous to the oscillator. It is passed through a two-flop synchronizer and a rising-edge detector, and everything runs on the oscillator clock `clk`.

The states are IDLE, GATE, SETTLE, ALIGN, MEASURE, JUDGE and FINISH. The transitions are:
- IDLE→GATE on an accepted start.
- GATE→SETTLE unconditionally.
- SETTLE→ALIGN on the last settling edge.
- ALIGN→MEASURE on the next reference edge.
- MEASURE→JUDGE on the last measuring edge.
- JUDGE→SETTLE when the count is high and retries remain.
- JUDGE→FINISH when the count is in range or the retry limit is reached.
- FINISH→IDLE unconditionally.

Top module: `fll_cal_seq`

## Requirements
- R1: After synchronous reset (`rst` high), the block is idle: `periph_en`=1, `loop_en`=0, `busy`=0, `done`=0, `err`=0 and `meas_count`=0.
- R2: A `start` sampled high while idle moves to GATE at that edge. `periph_en` is 0 in every state except IDLE and FINISH.
- R3: `loop_en` is 1 exactly while in SETTLE. SETTLE ends at the SETTLE_REFS-th synchronized rising reference edge it sees (default 32×32 = 1024).
- R4: `ref_in` is sampled by two flops, and a rising edge is the first synchronized 1 after a 0. Only rising edges are counted, and each edge is acted on at the third `clk` edge after `ref_in` is first sampled high.
- R5: After the loop is switched off, the block waits for one rising reference edge. It then counts `clk` cycles over MEAS_REFS reference periods (default 32), so a reference period of P cycles gives MEAS_REFS×P. The count saturates at 2^CNT_W−1, and `meas_count` shows it from the cycle after the last measuring edge until the next measurement ends.
- R6: If `meas_count` > `cnt_hi` (unsigned) and retries remain, the block returns to SETTLE in the next cycle. A count equal to or below `cnt_hi` goes to FINISH.
- R7: On the RETRY_MAX-th consecutive high result (default 8), the block goes to FINISH and sets `err`. `err` keeps its value until the next accepted start clears it.
- R8: `busy` is 1 in every state except IDLE. A `start` that arrives while busy (including the FINISH cycle) is ignored.
- R9: `done` is 1 for exactly one cycle (FINISH), and `periph_en` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all logic runs on it |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, asynchronous |
| start | input | 1 | Period tick requesting a calibration |
| cnt_hi | input | CNT_W | Upper bound on the measured count |
| loop_en | output | 1 | Lock-loop enable |
| periph_en | output | 1 | Enable for oscillator-clocked consumers |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Retry limit hit in last sequence |
| meas_count | output | CNT_W | Last measured oscillator count |

## Verification
The properties checked on every cycle are:
- the loop never runs while the consumers are enabled;
- `done` is a single cycle with the consumers on;
- an idle start always raises `busy`;
- the measured count and the error flag stay unchanged while idle.

Other behaviour only shows up in the bench's scenarios. These cover the exact cycle on which each reference edge takes effect, the measured count at different reference periods, saturation, a count exactly equal to the bound, a retry followed by a pass, and running out of retries.

// File: rtl/fll_cal_pkg.sv
package fll_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_SETTLE,
        ST_ALIGN,
        ST_MEASURE,
        ST_JUDGE,
        ST_FINISH
    } cal_state_t;
endpackage

// File: rtl/fll_ref_sync.sv
// Two-flop synchronizer for the reference clock plus rising-edge detect (R4)
module fll_ref_sync (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise
);
    logic [2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[1:0], ref_in};
    end

    assign rise = pipe[1] & ~pipe[2];
endmodule

// File: rtl/fll_edge_tally.sv
// Counts synchronized reference edges; flags the edge that reaches the limit
module fll_edge_tally #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign hit = inc && (cnt == limit - 1'b1);
endmodule

// File: rtl/fll_osc_meter.sv
// Saturating oscillator-cycle counter with a result register (R5)
module fll_osc_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             cap,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    assign nxt = (cnt == CMAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (run)   cnt <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)      result <= '0;
        else if (cap) result <= nxt;
    end
endmodule

// File: rtl/fll_cal_seq.sv
module fll_cal_seq
    import fll_cal_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETTLE_REFS = 1024,
    parameter int MEAS_REFS   = 32,
    parameter int RETRY_MAX   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_hi,
    output logic             loop_en,
    output logic             periph_en,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [CNT_W-1:0] meas_count
);
    localparam int MAXR = (SETTLE_REFS > MEAS_REFS) ? SETTLE_REFS : MEAS_REFS;
    localparam int TW   = $clog2(MAXR + 1);
    localparam int RW   = $clog2(RETRY_MAX + 1);
    localparam logic [TW-1:0] SET_LIM  = TW'(SETTLE_REFS);
    localparam logic [TW-1:0] MEAS_LIM = TW'(MEAS_REFS);
    localparam logic [RW-1:0] RLAST    = RW'(RETRY_MAX - 1);

    cal_state_t     state, state_nx;
    logic [RW-1:0]  retry;
    logic           rise, hit;
    logic [TW-1:0]  lim;
    logic           tally_clr, met_clr, met_run, met_cap;
    logic           high;

    fll_ref_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .rise   (rise)
    );

    assign lim       = (state == ST_MEASURE) ? MEAS_LIM : SET_LIM;
    assign tally_clr = rst || !((state == ST_SETTLE) || (state == ST_MEASURE));

    fll_edge_tally #(.W(TW)) u_tally (
        .clk   (clk),
        .clr   (tally_clr),
        .inc   (rise),
        .limit (lim),
        .hit   (hit)
    );

    assign met_clr = (state == ST_ALIGN);
    assign met_run = (state == ST_MEASURE);
    assign met_cap = (state == ST_MEASURE) && hit;

    fll_osc_meter #(.CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .clr    (met_clr),
        .run    (met_run),
        .cap    (met_cap),
        .result (meas_count)
    );

    assign high = (meas_count > cnt_hi);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_GATE;
            ST_GATE:    state_nx = ST_SETTLE;
            ST_SETTLE:  if (hit) state_nx = ST_ALIGN;
            ST_ALIGN:   if (rise) state_nx = ST_MEASURE;
            ST_MEASURE: if (hit) state_nx = ST_JUDGE;
            ST_JUDGE:   state_nx = (high && retry != RLAST) ? ST_SETTLE : ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register with retry counter and error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            retry <= '0;
            err   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) err <= 1'b0;
            if (state == ST_GATE) retry <= '0;
            if (state == ST_JUDGE && high) begin
                if (retry == RLAST) err <= 1'b1;
                else                retry <= retry + 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        loop_en   = 1'b0;
        periph_en = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   begin periph_en = 1'b1; busy = 1'b0; end
            ST_SETTLE: loop_en = 1'b1;
            ST_FINISH: begin periph_en = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/fll_cal_checker.sv
module fll_cal_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             loop_en,
    input logic             periph_en,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] meas_count
);
    p_loop_gated_r3: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> !periph_en);

    p_idle_periph_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (periph_en && !loop_en));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_periph_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> periph_en);

    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_meas_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(meas_count));

    p_err_idle_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(err));
endmodule

bind fll_cal_seq fll_cal_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .loop_en    (loop_en),
    .periph_en  (periph_en),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .meas_count (meas_count)
);

// File: tb/tb_fll_cal_seq.sv
`timescale 1ns/1ps
module tb_fll_cal_seq;
    localparam int CW   = 8;
    localparam int SETR = 4;
    localparam int MEAR = 4;
    localparam int RMAX = 3;
    localparam int CMAXV = 255;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cnt_hi = '0;
    logic          loop_en, periph_en, busy, done, err;
    logic [CW-1:0] meas_count;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    int half    = 4;
    int rcnt    = 0;
    int done_seen = 0;
    int bursts  = 0;
    logic prev_loop = 1'b0;

    always #2 clk = ~clk;

    fll_cal_seq #(.CNT_W(CW), .SETTLE_REFS(SETR), .MEAS_REFS(MEAR), .RETRY_MAX(RMAX)) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .start(start), .cnt_hi(cnt_hi),
        .loop_en(loop_en), .periph_en(periph_en), .busy(busy), .done(done),
        .err(err), .meas_count(meas_count)
    );

    // reference clock generator, period 2*half cycles
    always @(negedge clk) begin
        if (rcnt >= half - 1) begin
            rcnt   <= 0;
            ref_in <= ~ref_in;
        end else begin
            rcnt <= rcnt + 1;
        end
    end

    // behavioural reference model
    int ms = 0, mtally = 0, mmeter = 0, mres = 0, mretry = 0, merr = 0;
    int hist[$] = '{0, 0, 0};
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ms = 0; mtally = 0; mmeter = 0; mres = 0; mretry = 0; merr = 0;
            hist = '{0, 0, 0};
        end else begin
            bit rise;
            rise = (hist[1] == 1) && (hist[2] == 0);
            case (ms)
                0: if (start) begin ms = 1; merr = 0; end
                1: begin mretry = 0; mtally = 0; ms = 2; end
                2: if (rise) begin
                       if (mtally == SETR - 1) ms = 3; else mtally++;
                   end
                3: if (rise) begin ms = 4; mmeter = 0; mtally = 0; end
                4: begin
                       mmeter = (mmeter == CMAXV) ? mmeter : mmeter + 1;
                       if (rise) begin
                           if (mtally == MEAR - 1) begin mres = mmeter; ms = 5; end
                           else mtally++;
                       end
                   end
                5: if (mres > int'(cnt_hi)) begin
                       if (mretry == RMAX - 1) begin merr = 1; ms = 6; end
                       else begin mretry++; mtally = 0; ms = 2; end
                   end else ms = 6;
                default: ms = 0;
            endcase
            void'(hist.pop_back());
            hist.push_front(int'(ref_in));
        end
    end

    task automatic cmp(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            cmp("R3 loop_en",    int'(loop_en),   int'(ms == 2));
            cmp("R2 periph_en",  int'(periph_en), int'(ms == 0 || ms == 6));
            cmp("R8 busy",       int'(busy),      int'(ms != 0));
            cmp("R9 done",       int'(done),      int'(ms == 6));
            cmp("R7 err",        int'(err),       merr);
            cmp("R5 meas_count", int'(meas_count), mres);
            if (done) done_seen++;
            if (loop_en && !prev_loop) bursts++;
            prev_loop = loop_en;
        end
    end

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        misses++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cmp("R1 periph_en", int'(periph_en), 1);
        cmp("R1 loop_en", int'(loop_en), 0);
        cmp("R1 busy", int'(busy), 0);
        cmp("R1 meas_count", int'(meas_count), 0);

        // pass at P=8: count 32, bound 40; extra starts while busy are ignored (R8)
        half = 4; cnt_hi = 8'd40; done_seen = 0; bursts = 0;
        kick();
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        cmp("R5 count 4x8", int'(meas_count), 32);
        cmp("R6 single burst", bursts, 1);
        repeat (5) @(negedge clk);
        cmp("R8 one done per accepted start", done_seen, 1);
        cmp("R8 idle after ignored start", int'(busy), 0);

        // count equal to bound passes (R6)
        cnt_hi = 8'd32; bursts = 0;
        kick(); wait_done();
        cmp("R6 equal passes", bursts, 1);
        cmp("R7 no err", int'(err), 0);

        // retry limit (R7): always high
        cnt_hi = 8'd20; bursts = 0;
        kick(); wait_done();
        cmp("R7 bursts to limit", bursts, RMAX);
        cmp("R7 err set", int'(err), 1);
        repeat (4) @(negedge clk);
        cmp("R7 err held idle", int'(err), 1);

        // retry then pass (R6), err cleared by start (R7)
        cnt_hi = 8'd20; bursts = 0;
        kick();
        @(negedge clk);
        cmp("R7 err cleared on start", int'(err), 0);
        while (bursts < 2) @(negedge clk);
        cnt_hi = 8'd40;
        wait_done();
        cmp("R6 retry then pass", bursts, 2);
        cmp("R7 no err after pass", int'(err), 0);

        // different period (R5): P=12 -> 48
        half = 6; cnt_hi = 8'd60;
        kick(); wait_done();
        cmp("R5 count 4x12", int'(meas_count), 48);

        // saturation (R5): P=80 -> 320 clipped to 255
        half = 40; cnt_hi = 8'd255;
        kick(); wait_done();
        cmp("R5 saturated", int'(meas_count), 255);
        cmp("R6 saturated not high", int'(err), 0);

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule